// File: doc/BRIEF.md
# Security-Gated Interrupt State Bank

This block is the per-interrupt state store of an interrupt distributor. For every shared interrupt (IDs 32 up to `NUM_IRQ-1`) it keeps a group bit, an enable bit, a pending latch, an active bit, an edge/level configuration bit and a 2-bit non-secure permission code. Software reaches this state through a simple word-wide register bus that carries a secure-access attribute with every transfer. The enable, pending and active bits each have a set view and a clear view.

When security is enabled (`sec_disable` low), every non-secure access is filtered bit by bit. A bit can be reached when its interrupt is in the non-secure group, or when its permission code is high enough for that kind of register. The group and permission registers are reserved for the secure side. The interrupt input lines are registered once per clock. A rising edge sets the pending latch of an edge-triggered interrupt. For a level-triggered interrupt, the line itself shows up as pending for as long as it is high. The effective pending, enable and group vectors are exported to downstream selection logic.

Top module: `irq_state_bank`

## Requirements
- R1: Bitmap words covering IDs below 32 (word index 0) and IDs at or above `NUM_IRQ` read as zero, and writes to them change nothing.
- R2: Register offsets, as byte addresses with word index n = interrupts 32n..32n+31: group 0x080+4n, set-enable 0x100+4n, clear-enable 0x180+4n, set-pending 0x200+4n, clear-pending 0x280+4n, set-active 0x300+4n, clear-active 0x380+4n, edge-config 0x400+4n (1 = edge-triggered). Writing 1 to a bit of a set view sets that bit. Writing 1 to a bit of a clear view clears it. Writing 0 leaves it alone. Both views read the stored bits.
- R3: With `sec_disable` = 0, a non-secure access only reaches bits that pass a mask. The mask is the group word ORed with a mask derived from the permission codes. Bits outside the mask read zero and ignore writes. Secure accesses, and any access with `sec_disable` = 1, are not masked.
- R4: A permission code of 1 or more opens non-secure set-pending access to that interrupt. A code of 2 or more also opens clear-pending access and non-secure reads of both active views.
- R5: Non-secure writes to either active view, and any non-secure access to the enable or edge-config views, are masked by the group bit alone.
- R6: Reading a pending view returns the pending latch ORed with (registered line level AND NOT edge-triggered). The same value drives `pend_vec`.
- R7: A line that rises 0 to 1 sets the pending latch only when its interrupt is edge-triggered. A line that stays at the same level causes no update, so a cleared latch stays clear while the line is held high.
- R8: The group words are reachable only by a secure access, or by any access when `sec_disable` = 1. In every other case they read zero and ignore writes. The permission words are reachable only by a secure access with `sec_disable` = 0.
- R9: Permission words sit at 0x500+4k and cover interrupts 16k..16k+15, two bits per interrupt, with the lowest ID in bits [1:0]. Words with 16k below 32 or at or above `NUM_IRQ` read zero and ignore writes.
- R10: Reset clears every state bit, the registered line levels and `bus_rdata`.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd` and is zero in any cycle that does not follow a read. Unmapped offsets read zero and ignore writes, and no error is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_disable | input | 1 | 1 = single security state (no masking, permission words closed) |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_secure | input | 1 | 1 = secure access |
| bus_rdata | output | DATA_W | Read data, valid one cycle after `bus_rd` |
| irq_lines | input | NUM_IRQ-32 | Shared interrupt input lines, bit i = interrupt 32+i |
| pend_vec | output | NUM_IRQ-32 | Effective pending state |
| en_vec | output | NUM_IRQ-32 | Enable state |
| grp_vec | output | NUM_IRQ-32 | Group state |

## Verification
The access paths are tried in three ways: secure, non-secure with security enabled, and non-secure with `sec_disable` set. The same words are written with all ones through set, clear and permission-gated views, so the group mask, the code-1 mask and the code-2 mask each leave a different bit pattern. Out-of-range words, the internal word and unmapped offsets get all-ones writes and are then read back, which shows whether a decode leak reached the stored state. The interrupt lines are driven as a single edge pulse, as a held high level on an edge-triggered interrupt after its latch is cleared, and as a level-triggered line that goes high and then low. These patterns separate latching from the live level merge.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;

   localparam int WORD_BITS   = 32;
   localparam int CODE_BITS   = 2;
   localparam int CODE_SPAN   = WORD_BITS / CODE_BITS;
   localparam int MIN_ADDR_W  = 12;

   typedef enum logic [3:0] {
      RG_NONE,
      RG_GROUP,
      RG_SETEN,
      RG_CLREN,
      RG_SETPEND,
      RG_CLRPEND,
      RG_SETACT,
      RG_CLRACT,
      RG_EDGE,
      RG_CODE
   } region_e;

   // 128-byte blocks selected by address bits [11:7]
   function automatic region_e region_of(input logic [4:0] blk);
      case (blk)
         5'd1:    return RG_GROUP;
         5'd2:    return RG_SETEN;
         5'd3:    return RG_CLREN;
         5'd4:    return RG_SETPEND;
         5'd5:    return RG_CLRPEND;
         5'd6:    return RG_SETACT;
         5'd7:    return RG_CLRACT;
         5'd8:    return RG_EDGE;
         5'd10,
         5'd11:   return RG_CODE;
         default: return RG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/irq_state_decode.sv
module irq_state_decode
   import irq_state_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [4:0]        bank_idx,
   output logic [5:0]        code_idx
);

   logic upper_ok;

   generate
      if (ADDR_W > MIN_ADDR_W) begin : g_wide
         assign upper_ok = (addr[ADDR_W-1:MIN_ADDR_W] == '0);
      end else begin : g_exact
         assign upper_ok = 1'b1;
      end
   endgenerate

   assign region   = upper_ok ? region_of(addr[11:7]) : RG_NONE;
   assign bank_idx = addr[6:2];
   assign code_idx = addr[7:2];

endmodule

// File: rtl/irq_state_perm.sv
module irq_state_perm
   import irq_state_pkg::*;
(
   input  logic [WORD_BITS-1:0]           grp,
   input  logic [WORD_BITS*CODE_BITS-1:0] code,
   input  logic                           secure,
   input  logic                           ds,
   output logic [WORD_BITS-1:0]           m_grp,
   output logic [WORD_BITS-1:0]           m_ge1,
   output logic [WORD_BITS-1:0]           m_ge2
);

   logic                 open_all;
   logic [WORD_BITS-1:0] ge1;
   logic [WORD_BITS-1:0] ge2;

   assign open_all = secure | ds;

   genvar b;
   generate
      for (b = 0; b < WORD_BITS; b++) begin : g_bit
         assign ge1[b] = code[CODE_BITS*b+1] | code[CODE_BITS*b];
         assign ge2[b] = code[CODE_BITS*b+1];
      end
   endgenerate

   assign m_grp = open_all ? '1 : grp;
   assign m_ge1 = open_all ? '1 : (grp | ge1);
   assign m_ge2 = open_all ? '1 : (grp | ge2);

endmodule

// File: rtl/irq_state_word.sv
module irq_state_word
   import irq_state_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 code_lo,
   input  logic                 code_hi,
   input  logic                 wr_en,
   input  logic                 secure,
   input  logic                 ds,
   input  region_e              region,
   input  logic [WORD_BITS-1:0] wdata,
   input  logic [WORD_BITS-1:0] irq_in,
   output logic [WORD_BITS-1:0] rd_val,
   output logic [WORD_BITS-1:0] pend_eff,
   output logic [WORD_BITS-1:0] en_q,
   output logic [WORD_BITS-1:0] grp_q
);

   localparam int CW = WORD_BITS * CODE_BITS;

   logic [WORD_BITS-1:0] pend_q, act_q, edge_q, lvl_q;
   logic [CW-1:0]        code_q;
   logic [WORD_BITS-1:0] grp_n, en_n, pend_n, act_n, edge_n;
   logic [CW-1:0]        code_n;
   logic [WORD_BITS-1:0] m_grp, m_ge1, m_ge2, rise;
   logic                 wsel, priv, codes_ok;

   irq_state_perm u_perm (
      .grp    (grp_q),
      .code   (code_q),
      .secure (secure),
      .ds     (ds),
      .m_grp  (m_grp),
      .m_ge1  (m_ge1),
      .m_ge2  (m_ge2)
   );

   assign wsel     = wr_en & sel;
   assign priv     = secure | ds;
   assign codes_ok = secure & ~ds;
   assign rise     = irq_in & ~lvl_q & edge_q;
   assign pend_eff = pend_q | (lvl_q & ~edge_q);

   always_comb begin
      grp_n  = grp_q;
      en_n   = en_q;
      pend_n = pend_q;
      act_n  = act_q;
      edge_n = edge_q;
      code_n = code_q;
      if (wsel) begin
         case (region)
            RG_GROUP:   if (priv) grp_n = wdata;
            RG_SETEN:   en_n   = en_q | (wdata & m_grp);
            RG_CLREN:   en_n   = en_q & ~(wdata & m_grp);
            RG_SETPEND: pend_n = pend_q | (wdata & m_ge1);
            RG_CLRPEND: pend_n = pend_q & ~(wdata & m_ge2);
            RG_SETACT:  act_n  = act_q | (wdata & m_grp);
            RG_CLRACT:  act_n  = act_q & ~(wdata & m_grp);
            RG_EDGE:    edge_n = (edge_q & ~m_grp) | (wdata & m_grp);
            default:    ;
         endcase
      end
      if (wr_en && codes_ok && region == RG_CODE) begin
         if (code_lo) code_n[WORD_BITS-1:0]  = wdata;
         if (code_hi) code_n[CW-1:WORD_BITS] = wdata;
      end
      // a fresh edge is never lost to a clear in the same cycle
      pend_n = pend_n | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q  <= '0;
         en_q   <= '0;
         pend_q <= '0;
         act_q  <= '0;
         edge_q <= '0;
         code_q <= '0;
         lvl_q  <= '0;
      end else begin
         grp_q  <= grp_n;
         en_q   <= en_n;
         pend_q <= pend_n;
         act_q  <= act_n;
         edge_q <= edge_n;
         code_q <= code_n;
         lvl_q  <= irq_in;
      end
   end

   always_comb begin
      case (region)
         RG_GROUP:            rd_val = priv ? grp_q : '0;
         RG_SETEN, RG_CLREN:  rd_val = en_q & m_grp;
         RG_SETPEND:          rd_val = pend_eff & m_ge1;
         RG_CLRPEND:          rd_val = pend_eff & m_ge2;
         RG_SETACT, RG_CLRACT: rd_val = act_q & m_ge2;
         RG_EDGE:             rd_val = edge_q & m_grp;
         RG_CODE:             rd_val = !codes_ok ? '0 :
                                       (code_hi ? code_q[CW-1:WORD_BITS]
                                                : code_q[WORD_BITS-1:0]);
         default:             rd_val = '0;
      endcase
   end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
   import irq_state_pkg::*;
#(
   parameter int NUM_IRQ = 96,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sec_disable,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_secure,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_IRQ-33:0] irq_lines,
   output logic [NUM_IRQ-33:0] pend_vec,
   output logic [NUM_IRQ-33:0] en_vec,
   output logic [NUM_IRQ-33:0] grp_vec
);

   localparam int NUM_SPI   = NUM_IRQ - WORD_BITS;
   localparam int NUM_WORDS = NUM_SPI / WORD_BITS;
   localparam int CODE_BASE = WORD_BITS / CODE_SPAN;

   generate
      if ((NUM_IRQ % WORD_BITS) != 0 || NUM_IRQ < 2*WORD_BITS || NUM_IRQ > 1024) begin : g_bad_irq
         $error("NUM_IRQ must be a multiple of 32 between 64 and 1024");
      end
      if (DATA_W != WORD_BITS) begin : g_bad_data
         $error("DATA_W must equal the bitmap word width");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   region_e    region;
   logic [4:0] bank_idx;
   logic [5:0] code_idx;

   irq_state_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr     (bus_addr),
      .region   (region),
      .bank_idx (bank_idx),
      .code_idx (code_idx)
   );

   logic [WORD_BITS-1:0] rd_val [NUM_WORDS];
   logic [NUM_WORDS-1:0] word_hit, code_lo, code_hi;

   genvar w;
   generate
      for (w = 0; w < NUM_WORDS; w++) begin : g_word
         localparam int BANK_N = w + 1;
         localparam int CODE_N = CODE_BASE + 2*w;

         assign word_hit[w] = (region != RG_CODE) && (region != RG_NONE) &&
                              (bank_idx == 5'(BANK_N));
         assign code_lo[w]  = (region == RG_CODE) && (code_idx == 6'(CODE_N));
         assign code_hi[w]  = (region == RG_CODE) && (code_idx == 6'(CODE_N + 1));

         irq_state_word u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (word_hit[w]),
            .code_lo  (code_lo[w]),
            .code_hi  (code_hi[w]),
            .wr_en    (bus_wr),
            .secure   (bus_secure),
            .ds       (sec_disable),
            .region   (region),
            .wdata    (bus_wdata),
            .irq_in   (irq_lines[w*WORD_BITS +: WORD_BITS]),
            .rd_val   (rd_val[w]),
            .pend_eff (pend_vec[w*WORD_BITS +: WORD_BITS]),
            .en_q     (en_vec[w*WORD_BITS +: WORD_BITS]),
            .grp_q    (grp_vec[w*WORD_BITS +: WORD_BITS])
         );
      end
   endgenerate

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (word_hit[i] || code_lo[i] || code_hi[i]) rd_next = rd_val[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= bus_rd ? rd_next : '0;
   end

endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk #(
   parameter int NUM_IRQ = 96,
   parameter int DATA_W  = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sec_disable,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic                bus_secure,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_IRQ-33:0] en_vec,
   input logic [NUM_IRQ-33:0] grp_vec
);

   // R10: state seen one cycle after a reset cycle is all zero
   p_reset_clear_r10: assert property (@(posedge clk)
      !rst_n |=> (en_vec == '0 && grp_vec == '0 && bus_rdata == '0));

   // R11: no read strobe means zero data the next cycle
   p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

   // R2: the enable state moves only through a bus write
   p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(en_vec));

   // R8: a non-secure write with security on never moves the group state
   p_grp_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_secure && !sec_disable) |=> $stable(grp_vec));

   // R8: group state moves only through a bus write
   p_grp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(grp_vec));

endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sec_disable (sec_disable),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_secure  (bus_secure),
   .bus_rdata   (bus_rdata),
   .en_vec      (en_vec),
   .grp_vec     (grp_vec)
);

// File: tb/irq_state_bank_tb.sv
module irq_state_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_IRQ    = 96;
   localparam int NSPI       = NUM_IRQ - 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sec_disable = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_secure = 1'b0;
   logic [31:0]       bus_rdata;
   logic [NSPI-1:0]   irq_lines = '0;
   logic [NSPI-1:0]   pend_vec, en_vec, grp_vec;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_state_bank #(.NUM_IRQ(NUM_IRQ), .ADDR_W(12), .DATA_W(32)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sec_disable (sec_disable),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_wdata   (bus_wdata),
      .bus_secure  (bus_secure),
      .bus_rdata   (bus_rdata),
      .irq_lines   (irq_lines),
      .pend_vec    (pend_vec),
      .en_vec      (en_vec),
      .grp_vec     (grp_vec)
   );

   typedef struct packed {
      logic        wr;
      logic        sec;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 34;
   // sec_disable = 0, all lines low; reads compare against exp
   localparam vec_t TABLE [NV] = '{
      '{1'b1, 1'b1, 12'h084, 32'h000000F0, 32'h0, 4'd8},
      '{1'b0, 1'b1, 12'h084, 32'h0, 32'h000000F0, 4'd8},        // R8 secure sees group
      '{1'b0, 1'b0, 12'h084, 32'h0, 32'h0, 4'd8},               // R8 NS reads zero
      '{1'b1, 1'b0, 12'h084, 32'hFFFFFFFF, 32'h0, 4'd8},
      '{1'b0, 1'b1, 12'h084, 32'h0, 32'h000000F0, 4'd8},        // R8 NS write ignored
      '{1'b1, 1'b0, 12'h104, 32'hFFFFFFFF, 32'h0, 4'd5},
      '{1'b0, 1'b1, 12'h104, 32'h0, 32'h000000F0, 4'd5},        // R5 enable group-masked
      '{1'b0, 1'b0, 12'h184, 32'h0, 32'h000000F0, 4'd3},        // R3 NS read masked
      '{1'b1, 1'b1, 12'h184, 32'h00000030, 32'h0, 4'd2},
      '{1'b0, 1'b1, 12'h104, 32'h0, 32'h000000C0, 4'd2},        // R2 clear view
      '{1'b1, 1'b1, 12'h104, 32'h00000000, 32'h0, 4'd2},
      '{1'b0, 1'b1, 12'h104, 32'h0, 32'h000000C0, 4'd2},        // R2 zero write no effect
      '{1'b1, 1'b1, 12'h508, 32'h00000039, 32'h0, 4'd9},
      '{1'b0, 1'b1, 12'h508, 32'h0, 32'h00000039, 4'd9},        // R9 code word readback
      '{1'b0, 1'b0, 12'h508, 32'h0, 32'h0, 4'd8},               // R8 NS code read zero
      '{1'b1, 1'b0, 12'h204, 32'hFFFFFFFF, 32'h0, 4'd3},
      '{1'b0, 1'b1, 12'h204, 32'h0, 32'h000000F7, 4'd3},        // R3/R4 group | code>=1
      '{1'b0, 1'b0, 12'h284, 32'h0, 32'h000000F6, 4'd4},        // R4 code>=2 view
      '{1'b1, 1'b0, 12'h284, 32'hFFFFFFFF, 32'h0, 4'd4},
      '{1'b0, 1'b1, 12'h204, 32'h0, 32'h00000001, 4'd4},        // R4 clear-pending masked
      '{1'b1, 1'b1, 12'h304, 32'h0000000F, 32'h0, 4'd2},
      '{1'b0, 1'b0, 12'h304, 32'h0, 32'h00000006, 4'd4},        // R4 active read code>=2
      '{1'b1, 1'b0, 12'h384, 32'hFFFFFFFF, 32'h0, 4'd5},
      '{1'b0, 1'b1, 12'h384, 32'h0, 32'h0000000F, 4'd5},        // R5 active write group only
      '{1'b1, 1'b0, 12'h304, 32'hFFFFFFFF, 32'h0, 4'd5},
      '{1'b0, 1'b1, 12'h304, 32'h0, 32'h000000FF, 4'd5},        // R5 NS set-active on group
      '{1'b1, 1'b1, 12'h100, 32'hFFFFFFFF, 32'h0, 4'd1},
      '{1'b0, 1'b1, 12'h100, 32'h0, 32'h0, 4'd1},               // R1 internal word
      '{1'b1, 1'b1, 12'h10C, 32'hFFFFFFFF, 32'h0, 4'd1},
      '{1'b0, 1'b1, 12'h10C, 32'h0, 32'h0, 4'd1},               // R1 beyond NUM_IRQ
      '{1'b1, 1'b1, 12'h700, 32'hFFFFFFFF, 32'h0, 4'd11},
      '{1'b0, 1'b1, 12'h700, 32'h0, 32'h0, 4'd11},              // R11 unmapped
      '{1'b1, 1'b1, 12'h108, 32'hA5A5A5A5, 32'h0, 4'd2},
      '{1'b0, 1'b1, 12'h108, 32'h0, 32'hA5A5A5A5, 4'd2}         // R2 second word
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic sec, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_secure = sec; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic sec, input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_secure = sec; bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      @(negedge clk);
      check("R10 en_vec", 64'(en_vec), 64'h0);
      check("R10 grp_vec", 64'(grp_vec), 64'h0);
      check("R10 pend_vec", 64'(pend_vec), 64'h0);
      check("R10 rdata", 64'(bus_rdata), 64'h0);
      bus_read(1'b1, 12'h204, rd);
      check("R10 pending word", 64'(rd), 64'h0);

      for (int i = 0; i < NV; i++) begin
         if (TABLE[i].wr) begin
            bus_write(TABLE[i].sec, TABLE[i].addr, TABLE[i].data);
         end else begin
            bus_read(TABLE[i].sec, TABLE[i].addr, rd);
            check($sformatf("R%0d vector %0d", TABLE[i].req, i), 64'(rd), 64'(TABLE[i].exp));
         end
      end

      // R2: enable port reflects word 1
      check("R2 en_vec word1", 64'(en_vec[31:0]), 64'hC0);
      // R11: idle cycle after a read returns zero
      @(negedge clk);
      check("R11 idle rdata", 64'(bus_rdata), 64'h0);

      // R7/R6 on word 2 (interrupts 64..95): 64..79 edge-triggered
      bus_write(1'b1, 12'h408, 32'h0000FFFF);
      @(negedge clk); irq_lines[32] = 1'b1;
      @(negedge clk);
      bus_read(1'b1, 12'h208, rd);
      check("R7 edge latches", 64'(rd), 64'h1);
      bus_write(1'b1, 12'h288, 32'h00000001);
      @(negedge clk);
      bus_read(1'b1, 12'h208, rd);
      check("R7 held level no relatch", 64'(rd), 64'h0);
      irq_lines[48] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_read(1'b1, 12'h208, rd);
      check("R6 level merged", 64'(rd), 64'h00010000);
      check("R6 pend_vec level", 64'(pend_vec[63:32]), 64'h00010000);
      irq_lines[48] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      bus_read(1'b1, 12'h208, rd);
      check("R7 level line not latched", 64'(rd), 64'h0);
      irq_lines[32] = 1'b0;
      @(negedge clk);
      irq_lines[32] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_read(1'b1, 12'h208, rd);
      check("R7 second edge latches", 64'(rd), 64'h1);

      // R8/R3 with a single security state
      sec_disable = 1'b1;
      bus_write(1'b0, 12'h084, 32'h0000000F);
      bus_read(1'b0, 12'h084, rd);
      check("R8 NS group with DS=1", 64'(rd), 64'hF);
      check("R8 grp_vec", 64'(grp_vec[31:0]), 64'hF);
      bus_read(1'b1, 12'h508, rd);
      check("R8 codes RAZ with DS=1", 64'(rd), 64'h0);
      bus_write(1'b1, 12'h508, 32'h00000000);
      bus_write(1'b0, 12'h104, 32'hFFFFFFFF);
      check("R3 unmasked with DS=1", 64'(en_vec[31:0]), 64'hFFFFFFFF);
      sec_disable = 1'b0;
      bus_read(1'b1, 12'h508, rd);
      check("R8 code write ignored with DS=1", 64'(rd), 64'h39);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule